// File: doc/BRIEF.md
# Selectable-Scheme Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. A three-bit scheme selector picks one of six predictors. Three are static and consult no storage: never taken, always taken, and a backward/forward rule that compares the branch target with the branch address. The other three are dynamic and read a small untagged table indexed by address bits: a one-bit "same as last time" scheme, a two-bit saturating up/down counter, and a two-bit counter whose predicted direction flips only after two mispredictions in a row.

A lookup presents the branch address and its target and sees the guess combinationally on `pred_taken`. When the branch resolves, the pipeline presents its address and the real outcome on the update port with `upd_valid` high; the selected table entry changes on the next rising clock edge. The scheme selector is meant to stay fixed during operation; one shared table serves all dynamic schemes.

Each table entry holds one of four named states: SN (strongly not-taken, 00), WN (weakly not-taken, 01), WT (weakly taken, 10) and ST (strongly taken, 11). Saturating transitions: a taken outcome moves SN to WN, WN to WT, WT to ST, ST stays ST; a not-taken outcome moves ST to WT, WT to WN, WN to SN, SN stays SN. Hysteresis transitions: taken moves SN to WN, WN to ST, WT to ST, ST stays ST; not-taken moves ST to WT, WT to SN, WN to SN, SN stays SN. The last-time scheme writes WT on a taken outcome and SN on a not-taken outcome.

Top module: `bp_dir_predictor`

## Requirements
- R1: With scheme code 0 (never taken), `pred_taken` is 0 for every lookup.
- R2: With scheme code 1 (always taken), `pred_taken` is 1 for every lookup.
- R3: With scheme code 2 (backward/forward), `pred_taken` is 1 exactly when `lk_target` is numerically lower than `lk_pc`; an equal or higher target gives 0.
- R4: With scheme code 4 (saturating), each valid update moves the addressed entry one step up on a taken outcome and one step down on a not-taken one, holding at ST and SN; the prediction is the entry's upper bit (1 for WT and ST).
- R5: The table has 2^K entries selected by `pc[K+1:2]`, with no tag: addresses that agree in those bits share one entry, addresses that differ in them do not.
- R6: With scheme code 5 (hysteresis), an entry follows the hysteresis transitions listed above, so that a correct-direction entry flips its prediction only after two consecutive mispredictions.
- R7: With scheme code 3 (last-time), a valid update stores the actual outcome and the next prediction for that entry equals it.
- R8: After reset every entry is WT, so every dynamic scheme predicts taken for any address.
- R9: The table changes only on a clock edge with `upd_valid` high under a dynamic scheme (codes 3, 4, 5); with `upd_valid` low, or under codes 0, 1, 2, updates leave every entry untouched.
- R10: Scheme codes 6 and 7 are unused and predict not-taken.
- R11: A lookup in the same cycle as an update to the same entry returns the entry's value before the update; the new value is seen from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, sets every entry to WT |
| mode_sel | input | 3 | Scheme code: 0 never, 1 always, 2 backward/forward, 3 last-time, 4 saturating, 5 hysteresis |
| lk_pc | input | AW | Address of the branch being predicted |
| lk_target | input | AW | Target address of the branch being predicted |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | AW | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| pred_taken | output | 1 | Predicted direction, 1 for taken |

## Verification
The dynamic schemes are driven with outcome runs that walk an entry through every state and past both saturation ends, and the same not-taken-then-taken pattern from WT is applied under the saturating and hysteresis schemes, where the former predicts taken again and the latter stays not-taken, which separates the two state machines. Alternating outcomes under the last-time scheme show the one-bit follow. Target above, below and equal to the address pin down the backward/forward compare, and address pairs that differ above or inside bits K+1:2 show sharing against separation. Updates under static schemes or with the strobe low are followed by a switch to a dynamic scheme to read back the untouched entry.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [2:0] {
        SCH_NEVER  = 3'd0,
        SCH_ALWAYS = 3'd1,
        SCH_BACKFW = 3'd2,
        SCH_LAST   = 3'd3,
        SCH_SAT    = 3'd4,
        SCH_HYST   = 3'd5,
        SCH_RSV6   = 3'd6,
        SCH_RSV7   = 3'd7
    } bp_scheme_e;

    typedef enum logic [1:0] {
        CTR_SN = 2'b00,
        CTR_WN = 2'b01,
        CTR_WT = 2'b10,
        CTR_ST = 2'b11
    } bp_ctr_e;

    function automatic logic is_dynamic(input bp_scheme_e s);
        return (s == SCH_LAST) || (s == SCH_SAT) || (s == SCH_HYST);
    endfunction

endpackage

// File: rtl/bp_static_dir.sv
module bp_static_dir
    import bp_pkg::*;
#(
    parameter int AW = 32
) (
    input  bp_scheme_e    scheme,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] target,
    output logic          taken
);
    always_comb begin
        unique case (scheme)
            SCH_ALWAYS: taken = 1'b1;
            SCH_BACKFW: taken = (target < pc);
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
    import bp_pkg::*;
(
    input  bp_scheme_e scheme,
    input  bp_ctr_e    cur,
    input  logic       outcome,
    output bp_ctr_e    nxt
);
    bp_ctr_e sat_nxt;
    bp_ctr_e hys_nxt;

    always_comb begin
        unique case (cur)
            CTR_SN: sat_nxt = outcome ? CTR_WN : CTR_SN;
            CTR_WN: sat_nxt = outcome ? CTR_WT : CTR_SN;
            CTR_WT: sat_nxt = outcome ? CTR_ST : CTR_WN;
            CTR_ST: sat_nxt = outcome ? CTR_ST : CTR_WT;
            default: sat_nxt = CTR_WT;
        endcase
    end

    always_comb begin
        unique case (cur)
            CTR_SN: hys_nxt = outcome ? CTR_WN : CTR_SN;
            CTR_WN: hys_nxt = outcome ? CTR_ST : CTR_SN;
            CTR_WT: hys_nxt = outcome ? CTR_ST : CTR_SN;
            CTR_ST: hys_nxt = outcome ? CTR_ST : CTR_WT;
            default: hys_nxt = CTR_WT;
        endcase
    end

    always_comb begin
        unique case (scheme)
            SCH_LAST: nxt = outcome ? CTR_WT : CTR_SN;
            SCH_SAT:  nxt = sat_nxt;
            SCH_HYST: nxt = hys_nxt;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bp_dir_predictor.sv
module bp_dir_predictor
    import bp_pkg::*;
#(
    parameter int AW = 32,
    parameter int K  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_sel,
    input  logic [AW-1:0] lk_pc,
    input  logic [AW-1:0] lk_target,
    input  logic          upd_valid,
    input  logic [AW-1:0] upd_pc,
    input  logic          upd_taken,
    output logic          pred_taken
);
    localparam int ENTRIES = 1 << K;
    localparam int IDX_LO  = 2;
    localparam int IDX_HI  = K + 1;

    bp_scheme_e     scheme;
    bp_ctr_e        tbl [ENTRIES];
    logic [K-1:0]   lk_idx;
    logic [K-1:0]   upd_idx;
    bp_ctr_e        upd_old;
    bp_ctr_e        upd_new;
    logic           wr_en;
    logic           static_taken;
    bp_ctr_e        lk_entry;

    assign scheme   = bp_scheme_e'(mode_sel);
    assign lk_idx   = lk_pc[IDX_HI:IDX_LO];
    assign upd_idx  = upd_pc[IDX_HI:IDX_LO];
    assign upd_old  = tbl[upd_idx];
    assign lk_entry = tbl[lk_idx];
    assign wr_en    = upd_valid && is_dynamic(scheme);

    bp_static_dir #(.AW(AW)) u_static (
        .scheme (scheme),
        .pc     (lk_pc),
        .target (lk_target),
        .taken  (static_taken)
    );

    bp_ctr_next u_next (
        .scheme  (scheme),
        .cur     (upd_old),
        .outcome (upd_taken),
        .nxt     (upd_new)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl[i] <= CTR_WT;
            else if (wr_en && (upd_idx == K'(i)))
                tbl[i] <= upd_new;
        end
    end

    always_comb begin
        unique case (scheme)
            SCH_LAST, SCH_SAT, SCH_HYST: pred_taken = lk_entry[1];
            default:                     pred_taken = static_taken;
        endcase
    end

    // Checking support: entry index written at the previous edge
    logic [K-1:0] chk_idx;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_idx <= '0;
        else        chk_idx <= upd_idx;
    end

    AST_SAT_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && scheme == SCH_SAT && upd_taken && upd_old == CTR_ST)
        |=> tbl[chk_idx] == CTR_ST); // R4
    AST_SAT_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && scheme == SCH_SAT && !upd_taken && upd_old == CTR_SN)
        |=> tbl[chk_idx] == CTR_SN); // R4
    AST_HYST_WEAK_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && scheme == SCH_HYST && !upd_taken && upd_old == CTR_WT)
        |=> tbl[chk_idx] == CTR_SN); // R6
    AST_LAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && scheme == SCH_LAST)
        |=> tbl[chk_idx][1] == $past(upd_taken)); // R7
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid || !is_dynamic(scheme))
        |=> tbl[chk_idx] == $past(upd_old)); // R9
endmodule

// File: tb/bp_dir_predictor_test.sv
module bp_dir_predictor_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    mode_sel;
    logic [AW-1:0] lk_pc;
    logic [AW-1:0] lk_target;
    logic          upd_valid;
    logic [AW-1:0] upd_pc;
    logic          upd_taken;
    logic          pred_taken;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    bp_dir_predictor #(.AW(AW), .K(4)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .lk_pc(lk_pc), .lk_target(lk_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .pred_taken(pred_taken)
    );

    task automatic chk(input string req, input logic [AW-1:0] pc,
                       input logic [AW-1:0] tgt, input logic exp);
        lk_pc = pc;
        lk_target = tgt;
        #1;
        checks++;
        if (pred_taken !== exp) begin
            failures++;
            $display("FAIL %s pc=%h tgt=%h actual=%b expected=%b", req, pc, tgt, pred_taken, exp);
        end
    endtask

    task automatic upd(input logic [AW-1:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        mode_sel = 3'd4; chk("R8", 32'h100, 32'h0, 1'b1);
        mode_sel = 3'd5; chk("R8", 32'h13C, 32'h0, 1'b1);
        mode_sel = 3'd3; chk("R8", 32'h2A8, 32'h0, 1'b1);
    endtask

    task automatic t_static();
        mode_sel = 3'd0;
        chk("R1", 32'h40, 32'h10, 1'b0);
        chk("R1", 32'h40, 32'h80, 1'b0);
        mode_sel = 3'd1;
        chk("R2", 32'h40, 32'h10, 1'b1);
        chk("R2", 32'h40, 32'h80, 1'b1);
        mode_sel = 3'd2;
        chk("R3", 32'h400, 32'h3FC, 1'b1);
        chk("R3", 32'h400, 32'h404, 1'b0);
        chk("R3", 32'h400, 32'h400, 1'b0);
        chk("R3", 32'h8000_0000, 32'h0000_0004, 1'b1);
        mode_sel = 3'd6; chk("R10", 32'h400, 32'h3FC, 1'b0);
        mode_sel = 3'd7; chk("R10", 32'h400, 32'h3FC, 1'b0);
    endtask

    task automatic t_ignored_updates();
        do_reset();
        for (int m = 0; m < 3; m++) begin
            mode_sel = 3'(m);
            upd(32'h20, 1'b0);
            upd(32'h20, 1'b0);
        end
        mode_sel = 3'd4; chk("R9 static", 32'h20, 32'h0, 1'b1);
        upd(32'h20, 1'b0);
        chk("R9 sanity", 32'h20, 32'h0, 1'b0);
        @(negedge clk);
        upd_pc = 32'h24; upd_taken = 1'b0; upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 strobe low", 32'h24, 32'h0, 1'b1);
    endtask

    task automatic t_saturating();
        do_reset();
        mode_sel = 3'd4;
        upd(32'h30, 1'b0); chk("R4 WT->WN", 32'h30, 0, 1'b0);
        upd(32'h30, 1'b1); chk("R4 WN->WT", 32'h30, 0, 1'b1);
        upd(32'h30, 1'b1); upd(32'h30, 1'b1);
        upd(32'h30, 1'b0); chk("R4 top held", 32'h30, 0, 1'b1);
        upd(32'h30, 1'b0); chk("R4 WT->WN", 32'h30, 0, 1'b0);
        upd(32'h30, 1'b0); upd(32'h30, 1'b0);
        upd(32'h30, 1'b1); chk("R4 bottom held", 32'h30, 0, 1'b0);
        upd(32'h30, 1'b1); chk("R4 WN->WT", 32'h30, 0, 1'b1);
    endtask

    task automatic t_hysteresis();
        do_reset();
        mode_sel = 3'd5;
        upd(32'h30, 1'b0); chk("R6 WT->SN", 32'h30, 0, 1'b0);
        upd(32'h30, 1'b1); chk("R6 SN->WN", 32'h30, 0, 1'b0);
        upd(32'h30, 1'b1); chk("R6 WN->ST", 32'h30, 0, 1'b1);
        upd(32'h30, 1'b0); chk("R6 ST->WT", 32'h30, 0, 1'b1);
        upd(32'h30, 1'b1); chk("R6 WT->ST", 32'h30, 0, 1'b1);
        upd(32'h30, 1'b0); upd(32'h30, 1'b0);
        chk("R6 two misses flip", 32'h30, 0, 1'b0);
        upd(32'h30, 1'b0); chk("R6 SN held", 32'h30, 0, 1'b0);
    endtask

    task automatic t_last_time();
        do_reset();
        mode_sel = 3'd3;
        upd(32'h44, 1'b0); chk("R7", 32'h44, 0, 1'b0);
        upd(32'h44, 1'b1); chk("R7", 32'h44, 0, 1'b1);
        upd(32'h44, 1'b0); chk("R7", 32'h44, 0, 1'b0);
    endtask

    task automatic t_alias();
        do_reset();
        mode_sel = 3'd3;
        upd(32'h0000_0014, 1'b0);
        chk("R5 shared high bits", 32'h0000_0414, 0, 1'b0);
        chk("R5 shared low bits", 32'h0000_0017, 0, 1'b0);
        chk("R5 distinct index", 32'h0000_0018, 0, 1'b1);
        chk("R5 distinct index", 32'h0000_0010, 0, 1'b1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        mode_sel = 3'd3;
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h5C; upd_taken = 1'b0;
        chk("R11 old value", 32'h5C, 0, 1'b1);
        @(negedge clk);
        upd_valid = 1'b0;
        chk("R11 new value", 32'h5C, 0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; mode_sel = 3'd0; lk_pc = '0; lk_target = '0;
        upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
        t_reset_state();
        t_static();
        t_ignored_updates();
        t_saturating();
        t_hysteresis();
        t_last_time();
        t_alias();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule